// File: doc/BRIEF.md
# Configurable Serial Word Transmitter

This block takes 16-bit result words from a producer and shifts each one out on a serial line. It generates its own bit clock and a frame marker. Static configuration inputs choose four things: which bit-clock edge a receiver should sample on, whether the frame marker is a short pulse or a level that spans the data bits, whether each frame is 16 or 32 bit periods long, and the bit-clock rate. The bit clock runs continuously, and frames always begin on a bit-period boundary.

Words arrive through a one-cycle strobe. A word that arrives while a frame is being sent is held in a single pending slot. If a newer word arrives before that frame ends, it replaces the held word. The held word goes out back-to-back as soon as the current frame ends.

Several transmitters can share one serial line. Each one drives its data-enable output only when its enable input matches its time-slot select. An external alignment input lets several units restart their bit timing together. It cancels any frame in flight and restarts the bit period, and it leaves a held word waiting.

Top module: `ser_word_tx`

## Requirements
- R1: Words are sent most significant bit first. During period k of a frame (k = 0..15), `sdata` equals bit 15-k of the word, and `sdata` changes only at the start of a bit period.
- R2: Each bit period has two equal halves. With `cfg_edge_rise` = 1, `sclk` is low in the first half and high in the second, so data is valid on the rising edge. With `cfg_edge_rise` = 0, `sclk` is high in the first half and low in the second, so data is valid on the falling edge.
- R3: With `cfg_half_rate` = 0, a bit period lasts 2 `clk` cycles, so `sclk` toggles on every `clk` edge. With `cfg_half_rate` = 1, a bit period lasts 4 `clk` cycles.
- R4: `sdata_oe` is 1 exactly when `oe_in` equals `slot_sel`, and it follows them in the same cycle.
- R5: With `cfg_long_frame` = 1, a frame lasts 32 bit periods: 16 data bits, then 16 periods with `sdata` = 0. With `cfg_long_frame` = 0, a frame lasts 16 bit periods.
- R6: With `cfg_frame_level` = 0, `fsync_out` is 1 during the first bit period of each frame and 0 at all other times.
- R7: With `cfg_frame_level` = 1, `fsync_out` is 0 during the 16 data periods of a frame and 1 at all other times, including padding and idle.
- R8: A word is captured at the `clk` edge where `word_valid` is 1. Its frame begins at the next bit-period boundary after that edge. A boundary is the edge that ends the last `clk` cycle of a period.
- R9: A word captured during a frame is held until that frame ends, then sent with no gap. A newer capture replaces a word that has not started.
- R10: A `clk` edge with `fsync_in` = 1 ends any frame in flight and restarts the bit period at its first half. A held word is kept and begins at the next boundary.
- R11: During and right after reset, no frame is active, `sdata` = 0, and `sclk` is at its first-half level.
- R12: With no frame active, `sdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; a bit period is 2 or 4 of its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_valid | input | 1 | One-cycle strobe that captures `word_data` |
| word_data | input | 16 | Word to transmit |
| cfg_edge_rise | input | 1 | 1: data valid on the rising `sclk` edge; 0: on the falling edge |
| cfg_frame_level | input | 1 | 0: pulse frame marker; 1: active-low level marker |
| cfg_long_frame | input | 1 | 1: 32-period frame with zero padding; 0: 16-period frame |
| cfg_half_rate | input | 1 | 1: 4-cycle bit period; 0: 2-cycle bit period |
| oe_in | input | 1 | Line enable, compared with `slot_sel` |
| slot_sel | input | 1 | Level of `oe_in` that enables this unit |
| fsync_in | input | 1 | Alignment input that restarts bit timing |
| sclk | output | 1 | Generated bit clock |
| sdata | output | 1 | Serial data bit |
| sdata_oe | output | 1 | Drive enable for the serial data line |
| fsync_out | output | 1 | Frame marker |

## Verification
The hardest situations to reach are a word that is captured on the very edge where a frame ends, and an alignment pulse that arrives while a word is held. Either one exposes a wrong order between loading the slot and refilling it. The stimulus sweeps all sixteen configuration combinations. In each it sends bursts of words with random gaps, so that captures fall on every phase of the bit period, and it places alignment pulses in mid-frame while a word waits. A behavioural model compares every output on every clock.

// File: rtl/ser_word_tx_pkg.sv
package ser_word_tx_pkg;

    typedef enum logic {
        FS_PULSE = 1'b0,
        FS_LEVEL = 1'b1
    } fs_style_e;

endpackage

// File: rtl/ser_word_tx_clkgen.sv
module ser_word_tx_clkgen #(
    parameter int SLOW_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_half_rate,
    input  logic cfg_edge_rise,
    input  logic fsync_in,
    output logic period_end,
    output logic sclk
);
    localparam int PH_W = $clog2(2 * SLOW_DIV);

    typedef struct packed {
        logic [PH_W-1:0] ph;
    } clk_state_t;

    clk_state_t s_d, s_q;
    logic [PH_W:0] half_len;
    logic [PH_W:0] last_ph;
    logic          wrap;
    logic          second_half;

    always_comb begin
        s_d         = s_q;
        half_len    = cfg_half_rate ? (PH_W+1)'(SLOW_DIV) : (PH_W+1)'(1);
        last_ph     = (half_len << 1) - 1'b1;
        wrap        = {1'b0, s_q.ph} >= last_ph;
        second_half = {1'b0, s_q.ph} >= half_len;
        if (fsync_in || wrap) begin
            s_d.ph = '0;
        end else begin
            s_d.ph = s_q.ph + 1'b1;
        end
        period_end = wrap && !fsync_in;
        sclk       = cfg_edge_rise ? second_half : !second_half;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // R3: at full rate the bit clock changes level on every core clock edge
    a_r3_full_rate_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_half_rate && !fsync_in) |=>
            (sclk != $past(sclk)) || (cfg_edge_rise != $past(cfg_edge_rise))
            || (cfg_half_rate != $past(cfg_half_rate)));

    // R10: alignment restarts the period in its first half
    a_r10_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_in |=> (s_q.ph == '0));

endmodule

// File: rtl/ser_word_tx_framer.sv
module ser_word_tx_framer #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_end,
    input  logic              fsync_in,
    input  logic              cfg_long_frame,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              active,
    output logic              first_bit,
    output logic              data_phase,
    output logic              msb
);
    localparam int CNT_W = $clog2(2 * WORD_W);

    typedef struct packed {
        logic              active;
        logic [CNT_W-1:0]  bitn;
        logic [WORD_W-1:0] shreg;
        logic              pend;
        logic [WORD_W-1:0] pend_word;
    } frm_state_t;

    frm_state_t       s_d, s_q;
    logic [CNT_W-1:0] last_bit;

    always_comb begin
        s_d      = s_q;
        last_bit = cfg_long_frame ? CNT_W'(2 * WORD_W - 1) : CNT_W'(WORD_W - 1);
        if (fsync_in) begin
            s_d.active = 1'b0;
            s_d.bitn   = '0;
            s_d.shreg  = '0;
        end else if (period_end) begin
            if (s_q.active && (s_q.bitn != last_bit)) begin
                s_d.bitn  = s_q.bitn + 1'b1;
                s_d.shreg = s_q.shreg << 1;
            end else begin
                s_d.active = s_q.pend;
                s_d.bitn   = '0;
                s_d.shreg  = s_q.pend ? s_q.pend_word : '0;
                s_d.pend   = 1'b0;
            end
        end
        if (word_valid) begin
            s_d.pend      = 1'b1;
            s_d.pend_word = word_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active     = s_q.active;
    assign first_bit  = s_q.active && (s_q.bitn == '0);
    assign data_phase = s_q.active && (s_q.bitn < CNT_W'(WORD_W));
    assign msb        = s_q.shreg[WORD_W-1];

    // R9: a frame that has not reached its last bit keeps running
    a_r9_frame_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && (s_q.bitn != last_bit) && !fsync_in) |=> s_q.active);

    // R10: alignment cancels the frame in flight
    a_r10_abort: assert property (@(posedge clk) disable iff (!rst_n)
        fsync_in |=> (!s_q.active && (s_q.bitn == '0)));

    // R5: the padding periods carry only zeros
    a_r5_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && (s_q.bitn >= CNT_W'(WORD_W))) |-> (s_q.shreg == '0));

    // R8: a frame only starts from a held word
    a_r8_start_from_pend: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.active) |-> $past(s_q.pend));

endmodule

// File: rtl/ser_word_tx_outfmt.sv
module ser_word_tx_outfmt
    import ser_word_tx_pkg::*;
(
    input  logic      active,
    input  logic      first_bit,
    input  logic      data_phase,
    input  logic      msb,
    input  fs_style_e fs_style,
    input  logic      oe_in,
    input  logic      slot_sel,
    output logic      sdata,
    output logic      fsync_out,
    output logic      sdata_oe
);
    always_comb begin
        sdata     = active && msb;
        fsync_out = (fs_style == FS_LEVEL) ? !data_phase : first_bit;
        sdata_oe  = (oe_in == slot_sel);
    end

    // R12: idle line carries no data
    always_comb begin
        if (!active) begin
            a_r12_idle_low: assert (!sdata);
        end
    end

endmodule

// File: rtl/ser_word_tx.sv
module ser_word_tx
    import ser_word_tx_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int SLOW_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    input  logic              cfg_edge_rise,
    input  logic              cfg_frame_level,
    input  logic              cfg_long_frame,
    input  logic              cfg_half_rate,
    input  logic              oe_in,
    input  logic              slot_sel,
    input  logic              fsync_in,
    output logic              sclk,
    output logic              sdata,
    output logic              sdata_oe,
    output logic              fsync_out
);
    logic      period_end;
    logic      active;
    logic      first_bit;
    logic      data_phase;
    logic      msb;
    fs_style_e fs_style;

    assign fs_style = fs_style_e'(cfg_frame_level);

    ser_word_tx_clkgen #(
        .SLOW_DIV (SLOW_DIV)
    ) clkgen_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_half_rate (cfg_half_rate),
        .cfg_edge_rise (cfg_edge_rise),
        .fsync_in      (fsync_in),
        .period_end    (period_end),
        .sclk          (sclk)
    );

    ser_word_tx_framer #(
        .WORD_W (WORD_W)
    ) framer_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .period_end     (period_end),
        .fsync_in       (fsync_in),
        .cfg_long_frame (cfg_long_frame),
        .word_valid     (word_valid),
        .word_data      (word_data),
        .active         (active),
        .first_bit      (first_bit),
        .data_phase     (data_phase),
        .msb            (msb)
    );

    ser_word_tx_outfmt outfmt_i (
        .active     (active),
        .first_bit  (first_bit),
        .data_phase (data_phase),
        .msb        (msb),
        .fs_style   (fs_style),
        .oe_in      (oe_in),
        .slot_sel   (slot_sel),
        .sdata      (sdata),
        .fsync_out  (fsync_out),
        .sdata_oe   (sdata_oe)
    );

endmodule

// File: tb/ser_word_tx_tb_top.sv
`timescale 1ns/1ps
module ser_word_tx_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        cfg_edge_rise = 1'b0;
    logic        cfg_frame_level = 1'b0;
    logic        cfg_long_frame = 1'b0;
    logic        cfg_half_rate = 1'b0;
    logic        oe_in = 1'b0;
    logic        slot_sel = 1'b0;
    logic        fsync_in = 1'b0;
    logic        sclk, sdata, sdata_oe, fsync_out;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ser_word_tx dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .word_valid      (word_valid),
        .word_data       (word_data),
        .cfg_edge_rise   (cfg_edge_rise),
        .cfg_frame_level (cfg_frame_level),
        .cfg_long_frame  (cfg_long_frame),
        .cfg_half_rate   (cfg_half_rate),
        .oe_in           (oe_in),
        .slot_sel        (slot_sel),
        .fsync_in        (fsync_in),
        .sclk            (sclk),
        .sdata           (sdata),
        .sdata_oe        (sdata_oe),
        .fsync_out       (fsync_out)
    );

    // behavioural reference: clock count in period, bit queue of the frame, held words
    int          tcnt = 0;
    int          pos = 0;
    int          per;
    bit          fq[$];
    logic [15:0] pq[$];
    logic [15:0] w;

    always @(posedge clk) begin
        if (!rst_n) begin
            tcnt = 0;
            pos = 0;
            fq.delete();
            pq.delete();
        end else begin
            per = cfg_half_rate ? 4 : 2;
            if (fsync_in) begin
                tcnt = 0;
                pos = 0;
                fq.delete();
            end else if (tcnt >= per - 1) begin
                tcnt = 0;
                if (fq.size() > 1) begin
                    void'(fq.pop_front());
                    pos++;
                end else begin
                    fq.delete();
                    pos = 0;
                    if (pq.size() > 0) begin
                        w = pq.pop_front();
                        for (int i = 15; i >= 0; i--) fq.push_back(w[i]);
                        if (cfg_long_frame)
                            for (int i = 0; i < 16; i++) fq.push_back(1'b0);
                    end
                end
            end else begin
                tcnt++;
            end
            if (word_valid) begin
                pq.delete();
                pq.push_back(word_data);
            end
        end
    end

    task automatic chk(string tag, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        bit in_frame, sec;
        logic e_sd, e_fs;
        in_frame = (fq.size() > 0);
        sec = (tcnt >= (cfg_half_rate ? 2 : 1));
        e_sd = in_frame ? fq[0] : 1'b0;
        if (cfg_frame_level) e_fs = !(in_frame && pos < 16);
        else                 e_fs = in_frame && pos == 0;
        chk("R2 R3 sclk", sclk, cfg_edge_rise ? sec : !sec);
        chk("R1 R5 R8 R9 R10 R12 sdata", sdata, e_sd);
        chk("R6 R7 fsync_out", fsync_out, e_fs);
        chk("R4 sdata_oe", sdata_oe, oe_in == slot_sel);
    endtask

    task automatic step(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check_all();
        end
    endtask

    task automatic send(logic [15:0] d);
        word_valid = 1'b1;
        word_data  = d;
        step(1);
        word_valid = 1'b0;
    endtask

    task automatic align();
        fsync_in = 1'b1;
        step(1);
        fsync_in = 1'b0;
    endtask

    initial begin
        step(4);
        // R11: reset state seen at the ports
        chk("R11 sclk first-half level", sclk, 1'b1);
        chk("R11 sdata", sdata, 1'b0);
        chk("R11 fsync_out", fsync_out, 1'b0);
        rst_n = 1'b1;
        step(1);
        chk("R11 sdata after release", sdata, 1'b0);
        step(6);                         // R12 idle

        send(16'hA5C3);                  // R1 R6 R8 short frame, pulse, full rate
        step(40);

        cfg_long_frame = 1'b1; cfg_frame_level = 1'b1;
        cfg_edge_rise = 1'b1; cfg_half_rate = 1'b1;
        align();
        send(16'h8001);                  // R5 R7 long frame, half rate
        step(10);
        send(16'h7FFE);                  // R9 held mid-frame
        step(5);
        send(16'h1234);                  // R9 replaces the held word
        step(300);

        send(16'hFFFF);                  // R10 abort in flight
        step(20);
        align();
        step(60);
        send(16'h0F0F);
        step(6);
        send(16'hC3C3);
        step(3);
        align();                         // R10 held word survives
        step(200);

        for (int c = 0; c < 16; c++) begin
            cfg_edge_rise   = c[0];
            cfg_frame_level = c[1];
            cfg_long_frame  = c[2];
            cfg_half_rate   = c[3];
            align();
            for (int j = 0; j < 8; j++) begin
                send(16'($urandom));
                step(1 + ($urandom % 70));
            end
            step(140);
        end

        for (int m = 0; m < 4; m++) begin    // R4 every enable/slot pair
            oe_in = m[0];
            slot_sel = m[1];
            step(2);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule